// File: doc/BRIEF.md
# Jittered Cipher Operation Sequencer

This block wraps one block-cipher operation in timing padding so that an observer watching supply current cannot tell exactly when the computation starts or ends. A start command carries a key-size selection and an encrypt/decrypt flag. When padding is enabled, the sequencer waits a random number of cycles, launches the datapath, waits for it to finish, and then waits a second random number of cycles before it reports completion. The cipher rounds are represented by a latency model that finishes after a fixed number of cycles for each key size.

The random delays come from a free-running Galois LFSR. A test seed can be loaded into it so that a run can be reproduced. A busy output tells other agents that share the key and data store to keep away for the whole padded operation. Completion is latched in a sticky done flag, which software may poll or take as an interrupt.

Top module: `jitter_cipher_seq`

## Requirements
- R1: After reset, busy, core_active, op_decrypt, done, err and irq are all 0.
- R2: The key_len code selects the core latency L: 0 gives 55 cycles, 1 gives 70 and 2 gives 75. Code 3 behaves like code 2. With jitter_en low at the start edge, done first reads 1 exactly L+1 clock edges after the edge that samples start.
- R3: For every operation, in either mode, core_active is high for exactly L consecutive cycles.
- R4: With jitter_en high, the pre-delay lies between 0 and 15 cycles. The pre-delay is the count of edges from the start edge to the rise of core_active, minus one. The post-delay also lies between 0 and 15 cycles. It is the count of edges from the fall of core_active to the rise of done. The added latency therefore lies between 0 and 30 cycles.
- R5: With jitter, the pre-delay varies from one operation to the next, and the pre-delay and post-delay are drawn from separate LFSR bits, so they are not always equal.
- R6: Pulsing seed_load with a given seed and then starting an operation after the same number of cycles gives the same pre-delay and post-delay each time.
- R7: busy is 1 from the edge that samples start until the edge that sets done. On that edge busy falls and done rises together.
- R8: A start while busy is ignored: the running operation keeps its timing and its latched key size, and err is set.
- R9: done stays 1 until a clr_done pulse, after which it reads 0. err stays 1 until a clr_err pulse.
- R10: irq is 1 exactly when both done and irq_en are 1.
- R11: op_decrypt takes the value of decrypt at the start edge and holds it through the operation, even if decrypt changes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start command |
| key_len | input | 2 | Key size code: 0, 1, 2 (3 acts as 2) |
| decrypt | input | 1 | 1 selects decryption |
| jitter_en | input | 1 | Enables random padding for the operation being started |
| irq_en | input | 1 | Interrupt enable |
| clr_done | input | 1 | Write-one-to-clear pulse for done |
| clr_err | input | 1 | Write-one-to-clear pulse for err |
| seed_load | input | 1 | Loads seed into the LFSR (a zero seed is replaced by 1) |
| seed | input | 16 | LFSR test seed |
| busy | output | 1 | Operation in progress; the shared store is in use |
| core_active | output | 1 | Cipher datapath model running |
| op_decrypt | output | 1 | Direction latched for the current or last operation |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky flag for a start that arrived while busy |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that start, clr_done, clr_err and seed_load come from a synchronous agent and are valid at every edge after reset. They also assume reset is held for at least one edge before any command. The property that links a rising err to a start while busy relies on clr_err and start not being used to mask each other. The stimulus drives every input on the falling clock edge, holds reset for several cycles, and pulses each command for exactly one cycle. It clears done before each measured operation, so that timing is taken from the rise of done.

// File: rtl/jcs_pkg.sv
// Shared types and helpers for the jittered cipher sequencer.
// Assumes: none beyond the users of the package.
package jcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_CORE = 2'd2,
        ST_POST = 2'd3
    } jcs_state_e;

    // Largest of three latencies, used to size counters.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/jcs_lfsr.sv
// Free-running Galois LFSR that supplies the jitter values.
// Assumes: TAPS is a maximal-length mask for width W; a zero seed is replaced by 1.
module jcs_lfsr #(
    parameter int unsigned W         = 16,
    parameter logic [W-1:0] TAPS      = 16'hB400,
    parameter logic [W-1:0] SEED_INIT = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    output logic [W-1:0] value
);
    logic [W-1:0] q;
    logic [W-1:0] stepped;

    // Next state of a right-shifting Galois register.
    always_comb begin
        stepped = q >> 1;
        if (q[0]) stepped = stepped ^ TAPS;
    end

    // Advances every cycle, or takes the test seed.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= SEED_INIT;
        else if (load) q <= (seed == '0) ? {{(W-1){1'b0}}, 1'b1} : seed;
        else           q <= stepped;
    end

    assign value = q;

    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/jcs_delay_counter.sv
// Down counter for the pre and post padding; it stops at zero.
// Assumes: load has priority over counting.
module jcs_delay_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Loads a delay or counts it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/jcs_core_model.sv
// Latency model of the cipher datapath: it runs for a fixed count per key size.
// Assumes: go is only asserted while the model is idle.
module jcs_core_model #(
    parameter int unsigned LAT_A = 55,
    parameter int unsigned LAT_B = 70,
    parameter int unsigned LAT_C = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [1:0] key_sel,
    output logic       active,
    output logic       fin
);
    import jcs_pkg::*;
    localparam int unsigned LMAX = max3(LAT_A, LAT_B, LAT_C);
    localparam int unsigned CW   = $clog2(LMAX);

    logic [CW-1:0] ccnt;
    logic [CW-1:0] load_v;

    // Start value for the selected key size.
    always_comb begin
        case (key_sel)
            2'd0:    load_v = CW'(LAT_A - 1);
            2'd1:    load_v = CW'(LAT_B - 1);
            default: load_v = CW'(LAT_C - 1);
        endcase
    end

    assign fin = active && (ccnt == '0);

    // Runs the latency window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ccnt   <= '0;
        end else if (go) begin
            active <= 1'b1;
            ccnt   <= load_v;
        end else if (active) begin
            if (ccnt == '0) active <= 1'b0;
            else            ccnt   <= ccnt - 1'b1;
        end
    end

    assert_core_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !active);
    assert_core_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (32'(ccnt) < LMAX));
endmodule

// File: rtl/jitter_cipher_seq.sv
// Sequencer for one cipher operation, with optional random padding before and after.
// Assumes: start, clr_done, clr_err and seed_load are synchronous one-cycle pulses.
module jitter_cipher_seq #(
    parameter int unsigned LAT_128   = 55,
    parameter int unsigned LAT_192   = 70,
    parameter int unsigned LAT_256   = 75,
    parameter int unsigned DLY_W     = 4,
    parameter int unsigned LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        key_len,
    input  logic              decrypt,
    input  logic              jitter_en,
    input  logic              irq_en,
    input  logic              clr_done,
    input  logic              clr_err,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed,
    output logic              busy,
    output logic              core_active,
    output logic              op_decrypt,
    output logic              done,
    output logic              err,
    output logic              irq
);
    import jcs_pkg::*;

    jcs_state_e        state, nxt;
    logic              jit_q, dec_q, done_q, err_q;
    logic [1:0]        key_q;
    logic [LFSR_W-1:0] rnd;
    logic [DLY_W-1:0]  pre_draw, post_draw, dc_val;
    logic              dc_load, dc_zero, core_go, core_fin, set_done;

    jcs_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed), .value(rnd));

    jcs_delay_counter #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(dc_load), .load_val(dc_val), .zero(dc_zero));

    jcs_core_model #(.LAT_A(LAT_128), .LAT_B(LAT_192), .LAT_C(LAT_256)) u_core (
        .clk(clk), .rst_n(rst_n), .go(core_go), .key_sel(key_q),
        .active(core_active), .fin(core_fin));

    // Separate LFSR fields for the two delays; zero when padding is off.
    assign pre_draw  = jitter_en ? rnd[DLY_W-1:0]       : '0;
    assign post_draw = jit_q     ? rnd[2*DLY_W-1:DLY_W] : '0;

    // Phase sequencing: pre padding, core, post padding.
    always_comb begin
        nxt      = state;
        dc_load  = 1'b0;
        dc_val   = '0;
        core_go  = 1'b0;
        set_done = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                nxt     = ST_PRE;
                dc_load = 1'b1;
                dc_val  = pre_draw;
            end
            ST_PRE: if (dc_zero) begin
                core_go = 1'b1;
                nxt     = ST_CORE;
            end
            ST_CORE: if (core_fin) begin
                if (post_draw == '0) begin
                    set_done = 1'b1;
                    nxt      = ST_IDLE;
                end else begin
                    dc_load = 1'b1;
                    dc_val  = post_draw - 1'b1;
                    nxt     = ST_POST;
                end
            end
            default: if (dc_zero) begin
                set_done = 1'b1;
                nxt      = ST_IDLE;
            end
        endcase
    end

    // State register and the operation attributes latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            jit_q <= 1'b0;
            key_q <= 2'd0;
            dec_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                jit_q <= jitter_en;
                key_q <= key_len;
                dec_q <= decrypt;
            end
        end
    end

    // Sticky status flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (set_done)      done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (start && state != ST_IDLE) err_q <= 1'b1;
            else if (clr_err)              err_q <= 1'b0;
        end
    end

    assign busy       = (state != ST_IDLE);
    assign op_decrypt = dec_q;
    assign done       = done_q;
    assign err        = err_q;
    assign irq        = done_q & irq_en;

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(start && busy));
    assert_key_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(key_q));
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    assert_nojit_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE && !jit_q) |-> dc_zero);
    assert_post_needs_jit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> jit_q);
endmodule

// File: tb/jitter_cipher_seq_test.sv
module jitter_cipher_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, decrypt = 1'b0, jitter_en = 1'b0, irq_en = 1'b0;
    logic        clr_done = 1'b0, clr_err = 1'b0, seed_load = 1'b0;
    logic [1:0]  key_len = 2'd0;
    logic [15:0] seed = 16'h0;
    logic        busy, core_active, op_decrypt, done, err, irq;
    int          checks = 0, failures = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    jitter_cipher_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .decrypt(decrypt),
        .jitter_en(jitter_en), .irq_en(irq_en), .clr_done(clr_done), .clr_err(clr_err),
        .seed_load(seed_load), .seed(seed), .busy(busy), .core_active(core_active),
        .op_decrypt(op_decrypt), .done(done), .err(err), .irq(irq));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [1:0] k);
        return (k == 2'd0) ? 55 : (k == 2'd1) ? 70 : 75;
    endfunction

    task automatic pulse_clr_done();
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
    endtask

    // Runs one operation; kc = edges until core_active first high, ln = core cycles,
    // kd = edges until done high, all counted from the start edge.
    task automatic run_op(input logic [1:0] k, input logic dec, input logic jit,
                          input int inject_at, output int kc, output int ln,
                          output int kd, output bit dec_ok, output bit busy_ok);
        int n;
        kc = -1; ln = 0; kd = -1; dec_ok = 1'b1; busy_ok = 1'b1;
        @(negedge clk);
        start = 1'b1; key_len = k; decrypt = dec; jitter_en = jit;
        @(negedge clk);
        start = 1'b0; decrypt = ~dec; jitter_en = ~jit;
        n = 0;
        if (!busy || core_active || done) busy_ok = 1'b0;
        while (kd < 0 && n < 400) begin
            if (n == inject_at) begin
                start = 1'b1; key_len = 2'd0; decrypt = dec; jitter_en = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
            if (core_active) begin
                if (kc < 0) kc = n;
                ln++;
            end
            if (done) begin
                kd = n;
                if (busy) busy_ok = 1'b0;
            end else if (!busy) busy_ok = 1'b0;
            if (op_decrypt != dec) dec_ok = 1'b0;
        end
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && !core_active && !op_decrypt, "R1 busy/core/dir", busy, 0);
        check(!done && !err && !irq, "R1 flags", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !irq, "R1 after release", busy, 0);
    endtask

    task automatic t_nojit();
        int kc, ln, kd; bit dok, bok;
        for (int k = 0; k < 4; k++) begin
            run_op(2'(k), k[0], 1'b0, -1, kc, ln, kd, dok, bok);
            check(kd == lat_of(2'(k)) + 1, "R2 done edge", kd, lat_of(2'(k)) + 1);
            check(ln == lat_of(2'(k)), "R3 core length", ln, lat_of(2'(k)));
            check(bok, "R7 busy window", 0, 1);
            check(dok, "R11 direction held", 0, 1);
            pulse_clr_done();
        end
    endtask

    task automatic t_jitter();
        int kc, ln, kd, d1, d2, first_d1; bit dok, bok;
        bit varied = 1'b0, split = 1'b0, ranges_ok = 1'b1;
        first_d1 = -1;
        for (int i = 0; i < 10; i++) begin
            run_op(2'(i % 3), 1'b1, 1'b1, -1, kc, ln, kd, dok, bok);
            d1 = kc - 1;
            d2 = kd - kc - ln;
            if (d1 < 0 || d1 > 15 || d2 < 0 || d2 > 15) ranges_ok = 1'b0;
            if (ln != lat_of(2'(i % 3))) ranges_ok = 1'b0;
            if (first_d1 < 0) first_d1 = d1;
            else if (d1 != first_d1) varied = 1'b1;
            if (d1 != d2) split = 1'b1;
            check(bok, "R7 busy window jitter", 0, 1);
            repeat (i) @(negedge clk);
            pulse_clr_done();
        end
        check(ranges_ok, "R4 delay ranges and R3 core length", 0, 1);
        check(varied, "R5 pre-delay varies", 0, 1);
        check(split, "R5 pre and post differ", 0, 1);
    endtask

    task automatic t_seed();
        int kc, ln, kd, kc2, kd2; bit dok, bok;
        @(negedge clk); seed = 16'h3A5C; seed_load = 1'b1;
        @(negedge clk); seed_load = 1'b0;
        run_op(2'd1, 1'b0, 1'b1, -1, kc, ln, kd, dok, bok);
        pulse_clr_done();
        @(negedge clk); seed_load = 1'b1;
        @(negedge clk); seed_load = 1'b0;
        run_op(2'd1, 1'b0, 1'b1, -1, kc2, ln, kd2, dok, bok);
        check(kc2 == kc, "R6 same pre-delay", kc2, kc);
        check(kd2 == kd, "R6 same total", kd2, kd);
        pulse_clr_done();
    endtask

    task automatic t_busy_start();
        int kc, ln, kd; bit dok, bok;
        run_op(2'd2, 1'b1, 1'b0, 10, kc, ln, kd, dok, bok);
        check(kd == 76, "R8 timing unaffected", kd, 76);
        check(ln == 75, "R8 key size kept", ln, 75);
        check(dok, "R8/R11 direction kept", 0, 1);
        check(err, "R8 err set", err, 1);
        pulse_clr_done();
    endtask

    task automatic t_status();
        int kc, ln, kd; bit dok, bok;
        irq_en = 1'b0;
        run_op(2'd0, 1'b0, 1'b0, -1, kc, ln, kd, dok, bok);
        check(done && !irq, "R10 irq masked", irq, 0);
        repeat (20) @(negedge clk);
        check(done, "R9 done sticky", done, 1);
        check(err, "R9 err sticky", err, 1);
        irq_en = 1'b1;
        #1;
        check(irq, "R10 irq enabled", irq, 1);
        pulse_clr_done();
        check(!done && !irq, "R9 done cleared", done, 0);
        check(err, "R9 err untouched by clr_done", err, 1);
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        check(!err, "R9 err cleared", err, 0);
        irq_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nojit();
        t_jitter();
        t_seed();
        t_busy_start();
        t_status();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule